// File: doc/BRIEF.md
# Single-Level Paged Address Translator

This block maps 16-bit virtual addresses onto a 15-bit physical space. It holds a page table of sixteen entries in registers. The top four address bits select an entry. The low twelve bits pass through unchanged as the in-page offset. Each entry holds a valid-mapping flag and a 3-bit frame number. A mapped page has its frame number placed above the offset. An unmapped page gives a fault response that names the page, and no physical address goes out.

A configuration port loads entries on behalf of the supervising software. Each entry also tracks a used flag and a dirty flag, which the replacement policy elsewhere reads. Every response reports both flags as they stood before that access. A global clear input wipes all used flags at once, for periodic ageing. The block does not service faults, move pages to or from storage, or retry accesses.

Top module: `page_xlate`

## Requirements
- R1: After a synchronous reset, rsp_valid is 0, every table entry is unmapped with used and dirty flags at 0, and every later request faults until an entry is written.
- R2: A request accepted on a clock edge (req_valid high) produces rsp_valid high for exactly the following cycle. While rsp_valid is low, rsp_fault, rsp_paddr, rsp_fault_page, rsp_prev_used and rsp_prev_dirty are all 0.
- R3: The page index is req_vaddr[15:12] and selects one of 16 entries. The offset is req_vaddr[11:0].
- R4: For a mapped page, rsp_fault is 0 and rsp_paddr = {frame[2:0], offset[11:0]}. For example, page 0 mapped to frame 2 turns address 0 into 8192.
- R5: For an unmapped page, rsp_fault is 1, rsp_paddr is 0 and rsp_fault_page holds the page index. For example, address 32780 faults on page 8. On a hit, rsp_fault_page is 0.
- R6: A configuration write on an edge applies only to requests accepted on later edges. A request on the same edge sees the old entry.
- R7: A non-faulting access of any kind sets the entry's used flag. rsp_prev_used reports that flag as it was before the access.
- R8: Only a non-faulting write access (req_write=1) sets the dirty flag, and rsp_prev_dirty reports it as it was before the access. A read leaves the flag unchanged.
- R9: A faulting access changes neither flag of any entry.
- R10: used_clear clears every used flag and leaves dirty flags unchanged. An access that hits on the same edge still sets its own used flag.
- R11: A configuration write loads the mapped flag and the frame number, and clears the entry's used and dirty flags. This takes precedence over an access to that entry on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_page | input | 4 | Entry written |
| cfg_mapped | input | 1 | New mapped flag |
| cfg_frame | input | 3 | New frame number |
| used_clear | input | 1 | Clear all used flags |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 16 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Page not mapped |
| rsp_paddr | output | 15 | Physical address |
| rsp_fault_page | output | 4 | Faulting page index |
| rsp_prev_used | output | 1 | Used flag before this access |
| rsp_prev_dirty | output | 1 | Dirty flag before this access |

## Verification
Each response is due exactly one cycle after the edge that accepted its request. A table write or flag clear shows up only in responses to requests accepted on later edges. The bench drives each stimulus on the falling edge and computes the expected response from its behavioural table before applying that stimulus's updates. It samples all outputs shortly after the next rising edge and compares them on every cycle, idle cycles included. Same-edge collisions are driven on purpose: a write with a request, a clear with a hit, a write with an access.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int DEF_PAGE_W  = 4;
  localparam int DEF_OFF_W   = 12;
  localparam int DEF_FRAME_W = 3;
endpackage

// File: rtl/pg_table.sv
module pg_table #(
  parameter int PAGE_W  = pg_pkg::DEF_PAGE_W,
  parameter int FRAME_W = pg_pkg::DEF_FRAME_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [PAGE_W-1:0]  cfg_page,
  input  logic               cfg_mapped,
  input  logic [FRAME_W-1:0] cfg_frame,
  input  logic               used_clear,
  input  logic               acc_en,
  input  logic [PAGE_W-1:0]  acc_page,
  input  logic               acc_write,
  output logic               rd_mapped,
  output logic [FRAME_W-1:0] rd_frame,
  output logic               rd_used,
  output logic               rd_dirty
);
  localparam int ENTRIES = 1 << PAGE_W;

  logic [ENTRIES-1:0] mapped_q, used_q, dirty_q;
  logic [FRAME_W-1:0] frame_q [ENTRIES];
  logic               hit;

  assign rd_mapped = mapped_q[acc_page];
  assign rd_frame  = frame_q[acc_page];
  assign rd_used   = used_q[acc_page];
  assign rd_dirty  = dirty_q[acc_page];
  assign hit       = acc_en && rd_mapped;

  always_ff @(posedge clk) begin
    if (rst) begin
      mapped_q <= '0;
      used_q   <= '0;
      dirty_q  <= '0;
      for (int i = 0; i < ENTRIES; i++) frame_q[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (cfg_we && cfg_page == PAGE_W'(i)) begin
          mapped_q[i] <= cfg_mapped;
          frame_q[i]  <= cfg_frame;
          used_q[i]   <= 1'b0;
          dirty_q[i]  <= 1'b0;
        end else begin
          if (used_clear) used_q[i] <= 1'b0;
          if (hit && acc_page == PAGE_W'(i)) begin
            used_q[i] <= 1'b1;
            if (acc_write) dirty_q[i] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pg_resp.sv
module pg_resp #(
  parameter int PAGE_W  = pg_pkg::DEF_PAGE_W,
  parameter int OFF_W   = pg_pkg::DEF_OFF_W,
  parameter int FRAME_W = pg_pkg::DEF_FRAME_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     acc_en,
  input  logic [PAGE_W-1:0]        acc_page,
  input  logic [OFF_W-1:0]         acc_off,
  input  logic                     rd_mapped,
  input  logic [FRAME_W-1:0]       rd_frame,
  input  logic                     rd_used,
  input  logic                     rd_dirty,
  output logic                     rsp_valid,
  output logic                     rsp_fault,
  output logic [FRAME_W+OFF_W-1:0] rsp_paddr,
  output logic [PAGE_W-1:0]        rsp_fault_page,
  output logic                     rsp_prev_used,
  output logic                     rsp_prev_dirty
);
  always_ff @(posedge clk) begin
    if (rst || !acc_en) begin
      rsp_valid      <= 1'b0;
      rsp_fault      <= 1'b0;
      rsp_paddr      <= '0;
      rsp_fault_page <= '0;
      rsp_prev_used  <= 1'b0;
      rsp_prev_dirty <= 1'b0;
    end else begin
      rsp_valid      <= 1'b1;
      rsp_fault      <= !rd_mapped;
      rsp_paddr      <= rd_mapped ? {rd_frame, acc_off} : '0;
      rsp_fault_page <= rd_mapped ? '0 : acc_page;
      rsp_prev_used  <= rd_used;
      rsp_prev_dirty <= rd_dirty;
    end
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int PAGE_W  = pg_pkg::DEF_PAGE_W,
  parameter int OFF_W   = pg_pkg::DEF_OFF_W,
  parameter int FRAME_W = pg_pkg::DEF_FRAME_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [PAGE_W-1:0]         cfg_page,
  input  logic                      cfg_mapped,
  input  logic [FRAME_W-1:0]        cfg_frame,
  input  logic                      used_clear,
  input  logic                      req_valid,
  input  logic [PAGE_W+OFF_W-1:0]   req_vaddr,
  input  logic                      req_write,
  output logic                      rsp_valid,
  output logic                      rsp_fault,
  output logic [FRAME_W+OFF_W-1:0]  rsp_paddr,
  output logic [PAGE_W-1:0]         rsp_fault_page,
  output logic                      rsp_prev_used,
  output logic                      rsp_prev_dirty
);
  localparam int VA_W = PAGE_W + OFF_W;

  logic [PAGE_W-1:0]  acc_page;
  logic [OFF_W-1:0]   acc_off;
  logic               rd_mapped, rd_used, rd_dirty;
  logic [FRAME_W-1:0] rd_frame;

  assign acc_page = req_vaddr[VA_W-1 -: PAGE_W];
  assign acc_off  = req_vaddr[OFF_W-1:0];

  pg_table #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_table (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_page(cfg_page), .cfg_mapped(cfg_mapped), .cfg_frame(cfg_frame),
    .used_clear(used_clear),
    .acc_en(req_valid), .acc_page(acc_page), .acc_write(req_write),
    .rd_mapped(rd_mapped), .rd_frame(rd_frame), .rd_used(rd_used), .rd_dirty(rd_dirty)
  );

  pg_resp #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) u_resp (
    .clk(clk), .rst(rst),
    .acc_en(req_valid), .acc_page(acc_page), .acc_off(acc_off),
    .rd_mapped(rd_mapped), .rd_frame(rd_frame), .rd_used(rd_used), .rd_dirty(rd_dirty),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .rsp_fault_page(rsp_fault_page), .rsp_prev_used(rsp_prev_used),
    .rsp_prev_dirty(rsp_prev_dirty)
  );
endmodule

// File: rtl/pg_xlate_chk.sv
module pg_xlate_chk #(
  parameter int PAGE_W  = pg_pkg::DEF_PAGE_W,
  parameter int OFF_W   = pg_pkg::DEF_OFF_W,
  parameter int FRAME_W = pg_pkg::DEF_FRAME_W
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      req_valid,
  input logic [PAGE_W+OFF_W-1:0]   req_vaddr,
  input logic                      rsp_valid,
  input logic                      rsp_fault,
  input logic [FRAME_W+OFF_W-1:0]  rsp_paddr,
  input logic [PAGE_W-1:0]         rsp_fault_page,
  input logic                      rsp_prev_used,
  input logic                      rsp_prev_dirty
);
  localparam int VA_W = PAGE_W + OFF_W;

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_fault && rsp_paddr == '0 && rsp_fault_page == '0
                    && !rsp_prev_used && !rsp_prev_dirty));
  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_fault || rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));
  assert_fault_page_R5: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!rsp_fault || (rsp_fault_page == $past(req_vaddr[VA_W-1 -: PAGE_W])
                                  && rsp_paddr == '0)));
endmodule

bind page_xlate pg_xlate_chk #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
  .rsp_fault_page(rsp_fault_page), .rsp_prev_used(rsp_prev_used),
  .rsp_prev_dirty(rsp_prev_dirty)
);

// File: tb/page_xlate_tb.sv
module page_xlate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 0, cfg_mapped = 0, used_clear = 0, req_valid = 0, req_write = 0;
  logic [3:0]  cfg_page = 0;
  logic [2:0]  cfg_frame = 0;
  logic [15:0] req_vaddr = 0;
  logic        rsp_valid, rsp_fault, rsp_prev_used, rsp_prev_dirty;
  logic [14:0] rsp_paddr;
  logic [3:0]  rsp_fault_page;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_map[16], m_frame[16], m_used[16], m_dirty[16];

  always #2 clk = ~clk;

  page_xlate u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_page(cfg_page), .cfg_mapped(cfg_mapped),
    .cfg_frame(cfg_frame), .used_clear(used_clear), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_fault_page(rsp_fault_page),
    .rsp_prev_used(rsp_prev_used), .rsp_prev_dirty(rsp_prev_dirty)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One clock: drive on the falling edge, predict, sample after the rising edge.
  task automatic cyc(input string tag, input bit we, input int pg, input bit mp, input int fr,
                     input bit clr, input bit rv, input int va, input bit wr);
    int p, ev, ef, epa, efp, eu, ed;
    bit hit;
    @(negedge clk);
    cfg_we = we; cfg_page = 4'(pg); cfg_mapped = mp; cfg_frame = 3'(fr);
    used_clear = clr; req_valid = rv; req_vaddr = 16'(va); req_write = wr;
    p   = (va >> 12) & 15;
    hit = rv && m_map[p] != 0;
    ev  = rv ? 1 : 0;
    ef  = (rv && !hit) ? 1 : 0;
    epa = hit ? (m_frame[p] * 4096 + (va & 4095)) : 0;
    efp = ef ? p : 0;
    eu  = rv ? m_used[p] : 0;
    ed  = rv ? m_dirty[p] : 0;
    if (clr) for (int i = 0; i < 16; i++) m_used[i] = 0;
    if (hit) begin m_used[p] = 1; if (wr) m_dirty[p] = 1; end
    if (we) begin m_map[pg] = mp; m_frame[pg] = fr; m_used[pg] = 0; m_dirty[pg] = 0; end
    @(posedge clk); #1;
    chk({tag, " R2"}, "rsp_valid", rsp_valid, ev);
    chk({tag, " R5"}, "rsp_fault", rsp_fault, ef);
    chk({tag, " R4"}, "rsp_paddr", rsp_paddr, epa);
    chk({tag, " R5"}, "rsp_fault_page", rsp_fault_page, efp);
    chk({tag, " R7"}, "rsp_prev_used", rsp_prev_used, eu);
    chk({tag, " R8"}, "rsp_prev_dirty", rsp_prev_dirty, ed);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_map[i] = 0; m_frame[i] = 0; m_used[i] = 0; m_dirty[i] = 0; end
    repeat (3) @(posedge clk);
    #1 chk("R1", "rsp_valid in reset", rsp_valid, 0);
    @(negedge clk); rst = 0;
    // R1: every page faults after reset
    for (int i = 0; i < 16; i++) cyc("R1", 0, 0, 0, 0, 0, 1, i * 4096 + 7, 0);
    cyc("R2 idle", 0, 0, 0, 0, 0, 0, 0, 0);
    // R4: page 0 -> frame 2, address 0 gives 8192
    cyc("R4 cfg", 1, 0, 1, 2, 0, 0, 0, 0);
    cyc("R4 vaddr0", 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R4", "paddr of vaddr 0", rsp_paddr, 8192);
    // R5: address 32780 faults on page 8
    cyc("R5 vaddr32780", 0, 0, 0, 0, 0, 1, 32780, 0);
    chk("R5", "fault page of 32780", rsp_fault_page, 8);
    // R3: offset extremes and top page
    cyc("R3 cfg", 1, 15, 1, 7, 0, 0, 0, 0);
    cyc("R3 top", 0, 0, 0, 0, 0, 1, 16'hFFFF, 0);
    cyc("R3 base", 0, 0, 0, 0, 0, 1, 16'hF000, 0);
    // R6: write and request on same edge sees old entry
    cyc("R6 same edge", 1, 3, 1, 5, 0, 1, 16'h3123, 0);
    cyc("R6 next edge", 0, 0, 0, 0, 0, 1, 16'h3123, 0);
    // R7 R8: read then write then read
    cyc("R8 read", 0, 0, 0, 0, 0, 1, 16'h3001, 0);
    cyc("R8 write", 0, 0, 0, 0, 0, 1, 16'h3002, 1);
    cyc("R8 after write", 0, 0, 0, 0, 0, 1, 16'h3003, 0);
    // R9: faulting write leaves page 8 flags at 0 after mapping later
    cyc("R9 fault write", 0, 0, 0, 0, 0, 1, 16'h8000, 1);
    cyc("R9 fault again", 0, 0, 0, 0, 0, 1, 16'h8001, 1);
    // R10: clear with concurrent hit on page 0; page 3 loses used, keeps dirty
    cyc("R10 clear+hit", 0, 0, 0, 0, 1, 1, 16'h0004, 0);
    cyc("R10 page3", 0, 0, 0, 0, 0, 1, 16'h3000, 0);
    cyc("R10 page0", 0, 0, 0, 0, 0, 1, 16'h0000, 0);
    // R11: config write overrides access to same entry
    cyc("R11 write+acc", 1, 3, 1, 6, 0, 1, 16'h3010, 1);
    cyc("R11 after", 0, 0, 0, 0, 0, 1, 16'h3010, 0);
    cyc("R11 unmap", 1, 0, 0, 0, 0, 0, 0, 0);
    cyc("R11 unmapped", 0, 0, 0, 0, 0, 1, 16'h0010, 0);
    // mixed traffic against the model
    for (int n = 0; n < 400; n++)
      cyc("mix", ($urandom % 6) == 0, $urandom % 16, $urandom % 3 != 0, $urandom % 8,
          ($urandom % 20) == 0, $urandom % 4 != 0, $urandom % 65536, $urandom % 2);
    repeat (2) cyc("tail", 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule